// File: doc/BRIEF.md
# Periodic Frame Bandwidth Reservation Table

This block keeps a budget of bus byte-times for each of 32 consecutive frames and decides whether a new periodic endpoint fits. A request carries a cost in byte-times, a polling interval in frames and an opcode. An allocate request runs in three steps. It first rejects at once any cost that does not fit in the frame with the most room. It then walks all 32 frames and chooses the phase offset inside the interval whose busiest frame is least loaded. Last, it charges the cost to every frame that the endpoint visits at that offset, or to none of them.

A release request gives the cost back to the frames at a caller-supplied offset. A frame's load can never go below zero. The per-frame ceiling for periodic traffic is 1293 byte-times. It is what remains of a 1500 byte-time frame after 6 for start-of-frame, 4 for end-of-frame and 197 held back for non-periodic traffic.

The low five bits of a running frame number select one frame, whose committed load is shown on an output. Scheduling logic uses this output, and it also makes the table readable.

Top module: `bw_resv_table`

## Requirements
- R1: After reset every frame load is 0, `busy` is low and `done` is low.
- R2: The interval input is rounded down to the nearest of 1, 2, 4, 8, 16, 32 frames. Values 0 and 1 give 1, and values above 32 give 32.
- R3: A successful allocation with rounded interval N and chosen offset k (0 <= k < N) adds the cost to exactly the frames f where f mod N = k, and to no other frame.
- R4: The chosen offset is the k in 0..N-1 whose largest load among frames f mod N = k is smallest. On a tie the lowest k wins.
- R5: If the cost is larger than 1293 minus the smallest frame load, the request fails. `done` rises two cycles after acceptance, with no frame walk and no change to any load.
- R6: If the best offset's largest load plus the cost exceeds 1293, the request fails and no load changes.
- R7: A frame may be filled to exactly 1293. A request that would push any frame to 1294 fails.
- R8: A release with offset input o subtracts the cost from the frames f mod N = (o mod N), each saturating at 0. It always succeeds and reports o mod N on `done_offset`.
- R9: `busy` rises on the cycle after a request is accepted and stays high until `done`. A request presented while `busy` is high is ignored.
- R10: `active_load` shows the committed load of frame `frame_num[4:0]`. The upper bits of `frame_num` are ignored.
- R11: `done` is a one-cycle pulse. `done_ok` marks success, and `done_offset` gives the offset used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_free | input | 1 | 0 = allocate, 1 = release |
| req_cost | input | 11 | Cost in byte-times |
| req_interval | input | 6 | Polling interval in frames, before rounding |
| req_offset | input | 5 | Offset for a release (ignored on allocate) |
| frame_num | input | 11 | Running frame number; low 5 bits select the shown frame |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Completion succeeded |
| done_offset | output | 5 | Offset chosen or used |
| active_load | output | 11 | Committed load of the selected frame |

## Verification
The bench builds the block with its default parameters: 32 frames, 11-bit loads and a ceiling of 1293. These values are small enough to fill one frame exactly to the ceiling, and to see all 32 frames through `active_load` after every operation. Every interval class is reachable, including out-of-range values that must round down. Each result is compared against a frame-by-frame model in the bench. The requests are built so that offset ties, saturating release, both rejection paths (seen through their distinct latencies) and a request arriving while busy each occur.

// File: rtl/bw_resv_pkg.sv
package bw_resv_pkg;

    localparam int FRAMES            = 32;
    localparam int IDX_W             = $clog2(FRAMES);
    localparam int LOAD_W            = 11;
    localparam int INTV_W            = 6;
    localparam int FNUM_W            = 11;
    localparam int BUS_BYTES         = 1500;
    localparam int SOF_BYTES         = 6;
    localparam int EOF_BYTES         = 4;
    localparam int NONPERIODIC_BYTES = 197;
    localparam int PERIODIC_LIMIT    = BUS_BYTES - SOF_BYTES - EOF_BYTES - NONPERIODIC_BYTES;
    localparam int LG_W              = $clog2(IDX_W + 1);

    typedef logic [LOAD_W-1:0] load_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LG_W-1:0]   lg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FAST,
        ST_SCAN,
        ST_PICK,
        ST_COMMIT
    } state_t;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } op_t;

    typedef struct packed {
        op_t   op;
        load_t cost;
        lg_t   lg;
        idx_t  offset;
    } req_t;

    // Round an interval down to a power of two and return its log2,
    // clamped to the table size.
    function automatic lg_t interval_log2(input logic [INTV_W-1:0] v);
        lg_t r;
        r = '0;
        for (int b = 1; b <= IDX_W; b++) begin
            if (int'(v) >= (1 << b)) r = lg_t'(b);
        end
        return r;
    endfunction

    function automatic idx_t interval_mask(input lg_t lg);
        return idx_t'((1 << lg) - 1);
    endfunction

endpackage

// File: rtl/bw_frame_store.sv
module bw_frame_store
    import bw_resv_pkg::*;
#(
    parameter int N_FRAMES = FRAMES,
    parameter int L_W      = LOAD_W,
    localparam int I_W     = $clog2(N_FRAMES)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [I_W-1:0]                 wr_idx,
    input  logic [L_W-1:0]                 wr_data,
    input  logic [I_W-1:0]                 act_idx,
    output logic [L_W-1:0]                 act_load,
    output logic [N_FRAMES-1:0][L_W-1:0]   all_loads
);

    // One register per frame budget.
    for (genvar f = 0; f < N_FRAMES; f++) begin : g_frame
        always_ff @(posedge clk) begin
            if (rst) begin
                all_loads[f] <= '0;
            end else if (wr_en && (wr_idx == I_W'(f))) begin
                all_loads[f] <= wr_data;
            end
        end
    end

    assign act_load = all_loads[act_idx];

endmodule

// File: rtl/bw_min_finder.sv
module bw_min_finder
    import bw_resv_pkg::*;
#(
    parameter int N_FRAMES = FRAMES,
    parameter int L_W      = LOAD_W
) (
    input  logic [N_FRAMES-1:0][L_W-1:0] loads,
    output logic [L_W-1:0]               min_load
);

    always_comb begin
        min_load = loads[0];
        for (int f = 1; f < N_FRAMES; f++) begin
            if (loads[f] < min_load) min_load = loads[f];
        end
    end

endmodule

// File: rtl/bw_offset_picker.sv
module bw_offset_picker
    import bw_resv_pkg::*;
#(
    parameter int N_FRAMES = FRAMES,
    parameter int L_W      = LOAD_W,
    localparam int I_W     = $clog2(N_FRAMES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            acc_en,
    input  logic [I_W-1:0]  acc_idx,
    input  logic [L_W-1:0]  acc_load,
    input  logic [I_W-1:0]  mask,
    output logic [I_W-1:0]  best_off,
    output logic [L_W-1:0]  best_max
);

    logic [N_FRAMES-1:0][L_W-1:0] slot_max;
    logic [I_W-1:0]               slot;

    assign slot = acc_idx & mask;

    // Running maximum per phase slot while the frames are walked.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot_max <= '0;
        end else if (acc_en && (acc_load > slot_max[slot])) begin
            slot_max[slot] <= acc_load;
        end
    end

    // Lowest maximum among the slots in use; strict compare keeps the
    // lowest offset on a tie.
    always_comb begin
        best_off = '0;
        best_max = slot_max[0];
        for (int o = 1; o < N_FRAMES; o++) begin
            if ((I_W'(o) <= mask) && (slot_max[o] < best_max)) begin
                best_off = I_W'(o);
                best_max = slot_max[o];
            end
        end
    end

endmodule

// File: rtl/bw_resv_table.sv
module bw_resv_table
    import bw_resv_pkg::*;
#(
    parameter int N_FRAMES = FRAMES,
    parameter int L_W      = LOAD_W,
    parameter int IV_W     = INTV_W,
    parameter int FN_W     = FNUM_W,
    parameter int LIMIT    = PERIODIC_LIMIT,
    localparam int I_W     = $clog2(N_FRAMES),
    localparam int W_W     = I_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_free,
    input  logic [L_W-1:0]   req_cost,
    input  logic [IV_W-1:0]  req_interval,
    input  logic [I_W-1:0]   req_offset,
    input  logic [FN_W-1:0]  frame_num,
    output logic             busy,
    output logic             done,
    output logic             done_ok,
    output logic [I_W-1:0]   done_offset,
    output logic [L_W-1:0]   active_load
);

    state_t                      state_q;
    req_t                        lat_q;
    logic [W_W-1:0]              walk_q;
    logic [I_W-1:0]              walk_idx;
    logic [W_W-1:0]              step;
    logic [W_W-1:0]              next_walk;
    logic [I_W-1:0]              cur_mask;
    logic [N_FRAMES-1:0][L_W-1:0] loads;
    logic [L_W-1:0]              walk_load;
    logic [L_W-1:0]              min_load;
    logic [I_W-1:0]              best_off;
    logic [L_W-1:0]              best_max;
    logic                        fast_fail;
    logic                        pick_fail;
    logic                        wr_en;
    logic [L_W-1:0]              wr_data;
    logic [I_W-1:0]              in_mask;
    lg_t                         in_lg;

    // Request decode.
    assign in_lg    = interval_log2(req_interval);
    assign in_mask  = interval_mask(in_lg);
    assign cur_mask = interval_mask(lat_q.lg);
    assign step     = W_W'(1) << lat_q.lg;
    assign walk_idx = walk_q[I_W-1:0];
    assign next_walk = walk_q + step;
    assign walk_load = loads[walk_idx];

    // Limit tests carried one bit wider than a load.
    assign fast_fail = ({1'b0, lat_q.cost} + {1'b0, min_load}) > (L_W+1)'(LIMIT);
    assign pick_fail = ({1'b0, lat_q.cost} + {1'b0, best_max}) > (L_W+1)'(LIMIT);

    // Commit datapath: add on allocate, saturating subtract on release.
    assign wr_en = (state_q == ST_COMMIT);
    always_comb begin
        if (lat_q.op == OP_ALLOC) begin
            wr_data = walk_load + lat_q.cost;
        end else if (walk_load > lat_q.cost) begin
            wr_data = walk_load - lat_q.cost;
        end else begin
            wr_data = '0;
        end
    end

    bw_frame_store #(
        .N_FRAMES (N_FRAMES),
        .L_W      (L_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (walk_idx),
        .wr_data   (wr_data),
        .act_idx   (frame_num[I_W-1:0]),
        .act_load  (active_load),
        .all_loads (loads)
    );

    bw_min_finder #(
        .N_FRAMES (N_FRAMES),
        .L_W      (L_W)
    ) u_min (
        .loads    (loads),
        .min_load (min_load)
    );

    bw_offset_picker #(
        .N_FRAMES (N_FRAMES),
        .L_W      (L_W)
    ) u_pick (
        .clk      (clk),
        .rst      (rst),
        .clear    (state_q == ST_FAST),
        .acc_en   (state_q == ST_SCAN),
        .acc_idx  (walk_idx),
        .acc_load (walk_load),
        .mask     (cur_mask),
        .best_off (best_off),
        .best_max (best_max)
    );

    assign busy = (state_q != ST_IDLE);

    // Control sequence.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lat_q       <= '0;
            walk_q      <= '0;
            done        <= 1'b0;
            done_ok     <= 1'b0;
            done_offset <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_q.op     <= req_free ? OP_FREE : OP_ALLOC;
                        lat_q.cost   <= req_cost;
                        lat_q.lg     <= in_lg;
                        lat_q.offset <= req_offset & in_mask;
                        walk_q       <= {1'b0, req_offset & in_mask};
                        state_q      <= req_free ? ST_COMMIT : ST_FAST;
                    end
                end
                ST_FAST: begin
                    if (fast_fail) begin
                        done        <= 1'b1;
                        done_ok     <= 1'b0;
                        done_offset <= '0;
                        state_q     <= ST_IDLE;
                    end else begin
                        walk_q  <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (walk_idx == I_W'(N_FRAMES - 1)) begin
                        state_q <= ST_PICK;
                    end else begin
                        walk_q <= walk_q + W_W'(1);
                    end
                end
                ST_PICK: begin
                    if (pick_fail) begin
                        done        <= 1'b1;
                        done_ok     <= 1'b0;
                        done_offset <= best_off;
                        state_q     <= ST_IDLE;
                    end else begin
                        lat_q.offset <= best_off;
                        walk_q       <= {1'b0, best_off};
                        state_q      <= ST_COMMIT;
                    end
                end
                ST_COMMIT: begin
                    if (next_walk >= W_W'(N_FRAMES)) begin
                        done        <= 1'b1;
                        done_ok     <= 1'b1;
                        done_offset <= lat_q.offset;
                        state_q     <= ST_IDLE;
                    end else begin
                        walk_q <= next_walk;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bw_resv_table_chk.sv
module bw_resv_table_chk
    import bw_resv_pkg::*;
#(
    parameter int L_W   = LOAD_W,
    parameter int I_W   = IDX_W,
    parameter int LIMIT = PERIODIC_LIMIT
) (
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic           busy,
    input logic           done,
    input logic           done_ok,
    input logic [I_W-1:0] done_offset,
    input logic [L_W-1:0] active_load,
    input state_t         state,
    input lg_t            lg,
    input logic           fast_fail
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    active_limit_chk: assert property (@(posedge clk) disable iff (rst)
        active_load <= L_W'(LIMIT));

    // R3
    offset_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_ok) |-> ((done_offset >> lg) == '0));

    // R5
    fast_reject_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_FAST) && fast_fail) |=> (done && !done_ok));

endmodule

bind bw_resv_table bw_resv_table_chk #(
    .L_W   (L_W),
    .I_W   (I_W),
    .LIMIT (LIMIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .done_ok     (done_ok),
    .done_offset (done_offset),
    .active_load (active_load),
    .state       (state_q),
    .lg          (lat_q.lg),
    .fast_fail   (fast_fail)
);

// File: tb/bw_resv_table_test.sv
module bw_resv_table_test;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 32;
    localparam int LIM        = 1293;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_free = 1'b0;
    logic [10:0] req_cost = '0;
    logic [5:0]  req_interval = '0;
    logic [4:0]  req_offset = '0;
    logic [10:0] frame_num = '0;
    logic        busy;
    logic        done;
    logic        done_ok;
    logic [4:0]  done_offset;
    logic [10:0] active_load;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int model [NF];

    bw_resv_table uut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_free     (req_free),
        .req_cost     (req_cost),
        .req_interval (req_interval),
        .req_offset   (req_offset),
        .frame_num    (frame_num),
        .busy         (busy),
        .done         (done),
        .done_ok      (done_ok),
        .done_offset  (done_offset),
        .active_load  (active_load)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual %0d cycles, expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int round_intv(input int v);
        int n = 1;
        while ((n * 2 <= v) && (n < NF)) n = n * 2;
        return n;
    endfunction

    // Compare every frame through the frame-number port; upper bits vary (R10).
    task automatic verify_table(input string tag);
        for (int f = 0; f < NF; f++) begin
            frame_num = 11'(f + 32 * (f % 5 + 1));
            #1;
            check(int'(active_load) == model[f], $sformatf("%s frame %0d (R10)", tag, f),
                  int'(active_load), model[f]);
        end
    endtask

    // Issue a request at a falling edge and wait for completion.
    task automatic issue(input bit free, input int cost, input int intv, input int off,
                         input bit poke_busy, output int lat);
        @(negedge clk);
        req_valid    = 1'b1;
        req_free     = free;
        req_cost     = 11'(cost);
        req_interval = 6'(intv);
        req_offset   = 5'(off);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        while (!done && lat < 200) begin
            if (poke_busy && lat == 3) begin
                req_valid    = 1'b1;
                req_free     = 1'b1;
                req_cost     = 11'(2000);
                req_interval = 6'd1;
                req_offset   = 5'd0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R11 done seen", int'(done), 1);
        check(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    endtask

    // Allocation against the model (R3, R4, R5, R6, R7).
    task automatic do_alloc(input int cost, input int intv, input bit poke_busy, input string tag);
        int n, mn, best, bmax, lat;
        bit exp_fast, exp_ok;
        n  = round_intv(intv);
        mn = model[0];
        for (int f = 1; f < NF; f++) if (model[f] < mn) mn = model[f];
        best = 0;
        bmax = -1;
        for (int o = 0; o < n; o++) begin
            int mx = 0;
            for (int f = o; f < NF; f += n) if (model[f] > mx) mx = model[f];
            if (bmax < 0 || mx < bmax) begin
                bmax = mx;
                best = o;
            end
        end
        exp_fast = cost > LIM - mn;
        exp_ok   = !exp_fast && (bmax + cost <= LIM);
        issue(1'b0, cost, intv, 0, poke_busy, lat);
        check(done_ok == exp_ok, {tag, " R6 R7 ok flag"}, int'(done_ok), int'(exp_ok));
        if (exp_fast) begin
            check(lat <= 2, {tag, " R5 fast reject latency"}, lat, 2);
        end else begin
            check(lat >= 34, {tag, " R5 scan latency"}, lat, 34);
        end
        if (exp_ok) begin
            check(int'(done_offset) == best, {tag, " R4 offset"}, int'(done_offset), best);
            for (int f = best; f < NF; f += n) model[f] += cost;
        end
        @(negedge clk);
        check(done == 1'b0, {tag, " R11 pulse"}, int'(done), 0);
        verify_table({tag, " R3"});
    endtask

    task automatic do_free(input int cost, input int intv, input int off, input string tag);
        int n, k, lat;
        n = round_intv(intv);
        k = off % n;
        issue(1'b1, cost, intv, off, 1'b0, lat);
        check(done_ok == 1'b1, {tag, " R8 ok"}, int'(done_ok), 1);
        check(int'(done_offset) == k, {tag, " R8 offset"}, int'(done_offset), k);
        for (int f = k; f < NF; f += n) model[f] = (model[f] > cost) ? model[f] - cost : 0;
        verify_table({tag, " R8"});
    endtask

    task automatic t_reset();
        for (int f = 0; f < NF; f++) model[f] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        verify_table("R1 reset");
    endtask

    task automatic t_offsets();
        do_alloc(100, 4, 1'b0, "R3 interval 4");
        do_alloc(50, 4, 1'b0, "R4 tie lowest");
        do_alloc(10, 6, 1'b0, "R2 six to four");
        do_alloc(20, 1, 1'b0, "R3 every frame");
        do_alloc(5, 40, 1'b0, "R2 clamp to 32");
    endtask

    task automatic t_release();
        do_free(30, 2, 3, "R8 saturate");
    endtask

    task automatic t_limits();
        do_alloc(LIM, 32, 1'b0, "R7 exact fill");
        do_alloc(1, 1, 1'b0, "R6 one over");
        do_alloc(LIM + 1, 32, 1'b0, "R5 fast");
    endtask

    task automatic t_busy();
        do_alloc(7, 8, 1'b1, "R9 ignore while busy");
        do_alloc(3, 0, 1'b0, "R2 zero to one");
    endtask

    initial begin
        t_reset();
        t_offsets();
        t_release();
        t_limits();
        t_busy();
        finish_run();
    end

endmodule